// File: doc/BRIEF.md
# Offset-Calibration Window and GPO Override Sequencer

This block times the offset-calibration phase of a receive path. A run begins on a rising edge of the receive-enable pin, if the arm bit is set, or on a self-clearing start command. A start command is accepted only while receive-enable is high. Each run opens two windows at the same instant, and each window closes on its own. The first window is the span in which the analog correction loop may adapt. When it closes, the loop's result stays frozen until the next run. The second window can mute the low-noise amplifiers and can force the two general-purpose output pins to a calibration pattern.

Both windows are counted in ticks. One tick is the reference clock divided by 16. A half-rate bit doubles the divider so that a 52 MHz reference gives the same tick period as a 26 MHz one. The two output pins show a normal field from configuration. While the transmit-enable pin is high, a transmit override field can replace the normal field, and the transmit override takes priority over the calibration override. A test selector can put internal timing signals on the first pin for bring-up.

The receive-enable and transmit-enable pins are asynchronous to the reference clock. Each passes through a configurable synchronizer before the block uses it. The block holds no software-visible state of its own. All fields arrive from an external register file, which clears the start bit when the block raises the acknowledge output.

Top module: `calwin_seq`

## Requirements
- R1: While reset is asserted and after reset, with no run taken, `cal_active`, `lna_mute` and `start_ack` are low. The pins show `gpo_norm`, with bit 0 on `gpo1` and bit 1 on `gpo2`.
- R2: A rising edge on `rx_en_pin` starts a run only while `cal_arm` is high. With `cal_arm` low, such an edge leaves all outputs at their idle values.
- R3: While `start_cmd` and the synchronized receive-enable are both high, `start_ack` is high in that same cycle, and a run starts at the next clock edge. With receive-enable low, the command is neither acknowledged nor acted on.
- R4: One tick lasts 16 reference cycles when `half_rate` is 0 and 32 cycles when it is 1. The prescaler restarts at the trigger, so the first tick comes 16 (or 32) cycles after the run starts.
- R5: `cal_active` rises at the third clock edge after a rising edge on `rx_en_pin`, which covers two synchronizer stages and one edge-detect stage. It stays high for exactly `win1_len` ticks. Afterwards it stays low until another run starts.
- R6: When `mute_en` is 1, `lna_mute` is high for exactly `win2_len` ticks from the start of the run. When `mute_en` is 0, `lna_mute` never rises.
- R7: When `cal_ovr_en` is 1, the pins show `cal_ovr_val` for exactly the second window and then return to `gpo_norm`. When `cal_ovr_en` is 0, the pins keep `gpo_norm`.
- R8: When `tx_ovr_en` is 1, the pins show `tx_ovr_val` from the second edge after `tx_en_pin` rises to the second edge after it falls. This override takes priority over the calibration override.
- R9: A new trigger during a run restarts both windows from zero with newly sampled lengths.
- R10: A window length of zero closes that window at once. It then causes no active cycle, no mute cycle and no override cycle.
- R11: `test_sel` sets what `gpo1` carries: 00 gives the normal pin value, 01 gives bit 0 of the first-window tick counter, 10 gives the tick strobe, and 11 gives bit 0 of the second-window tick counter. `gpo2` is unaffected by `test_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (26 or 52 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_pin | input | 1 | Receive-enable pin, asynchronous |
| tx_en_pin | input | 1 | Transmit-enable pin, asynchronous |
| cal_arm | input | 1 | Allow receive-enable rising edges to start runs |
| start_cmd | input | 1 | Self-clearing start command bit |
| half_rate | input | 1 | Extra divide-by-two for a 52 MHz reference |
| win1_len | input | 8 | First window length in ticks |
| win2_len | input | 10 | Second window length in ticks |
| mute_en | input | 1 | Mute the amplifiers during the second window |
| cal_ovr_en | input | 1 | Enable the calibration pin override |
| cal_ovr_val | input | 2 | Pin values during the calibration override |
| tx_ovr_en | input | 1 | Enable the transmit pin override |
| tx_ovr_val | input | 2 | Pin values while transmit-enable is high |
| gpo_norm | input | 2 | Normal pin values |
| test_sel | input | 2 | Source select for gpo1 |
| cal_active | output | 1 | First window open: correction loop adapting |
| lna_mute | output | 1 | Amplifier mute |
| gpo1 | output | 1 | General-purpose pin 1 |
| gpo2 | output | 1 | General-purpose pin 2 |
| start_ack | output | 1 | Clears the start command bit |

## Verification
The bench sweeps both divider rates against many pairs of window lengths, including zero, one, odd and even values. It counts how many cycles each output is high, so an off-by-one in the tick compare or a prescaler that is not cleared at the trigger shows up as a count that is short or long by a tick. It restarts a run partway through. A design that ignored the restart, or resumed the old count, would show a total that is too short. It also raises transmit-enable during a calibration override; a design with the wrong priority would show the calibration pattern on the pins. Finally, it issues the start command with receive-enable low and runs with the arm bit clear, which catches a design that acts on either of them.

// File: rtl/cws_pkg.sv
package cws_pkg;

  // gpo1 source selected by the test field
  typedef enum logic [1:0] {
    TSEL_NORMAL = 2'b00,
    TSEL_W1LSB  = 2'b01,
    TSEL_TICK   = 2'b10,
    TSEL_W2LSB  = 2'b11
  } tsel_e;

  // winner of the pin-value priority
  typedef enum logic [1:0] {
    GSRC_NORM = 2'b00,
    GSRC_CAL  = 2'b01,
    GSRC_TX   = 2'b10
  } gsrc_e;

endpackage

// File: rtl/cws_sync.sv
module cws_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;

  generate
    if (STAGES == 1) begin : g_single
      assign pipe_n = d;
    end else begin : g_chain
      assign pipe_n = {pipe_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_n;
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/cws_tick.sv
module cws_tick #(
  parameter int unsigned DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic half_rate,
  output logic tick
);

  localparam int unsigned PW = DIV_LOG2 + 1;

  logic [PW-1:0] presc_q;
  logic [PW-1:0] presc_n;
  logic [PW-1:0] last;
  logic          presc_en;

  assign last = {half_rate, {DIV_LOG2{1'b1}}};
  assign tick = run & ~clr & (presc_q == last);

  always_comb begin
    presc_en = clr | run | (presc_q != '0);
    if (clr || !run)  presc_n = '0;
    else if (tick)    presc_n = '0;
    else              presc_n = presc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc_q <= '0;
    else if (presc_en) presc_q <= presc_n;
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R4

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (presc_q == '0) || $past(run)); // R4

endmodule

// File: rtl/cws_window.sv
module cws_window #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig,
  input  logic         tick,
  input  logic [W-1:0] len,
  output logic         active,
  output logic         cnt_lsb
);

  logic         active_q, active_n;
  logic [W-1:0] cnt_q, cnt_n, cnt_inc;
  logic [W-1:0] len_q, len_n;
  logic         load;

  assign cnt_inc = cnt_q + W'(1);

  always_comb begin
    load     = trig | (active_q & tick);
    active_n = active_q;
    cnt_n    = cnt_q;
    len_n    = len_q;
    if (trig) begin
      len_n    = len;
      active_n = |len;
      cnt_n    = '0;
    end else if (active_q && tick) begin
      if (cnt_inc == len_q) begin
        active_n = 1'b0;
        cnt_n    = '0;
      end else begin
        cnt_n = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
    end else if (load) begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
      len_q    <= len_n;
    end
  end

  assign active  = active_q;
  assign cnt_lsb = cnt_q[0];

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < len_q)); // R5

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (cnt_q == '0)); // R5

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && len == '0) |=> !active_q); // R10

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && len != '0) |=> (active_q && cnt_q == '0)); // R9

endmodule

// File: rtl/cws_gpo_mux.sv
module cws_gpo_mux
  import cws_pkg::*;
(
  input  logic [1:0] norm_val,
  input  logic [1:0] cal_val,
  input  logic [1:0] tx_val,
  input  logic       cal_sel,
  input  logic       tx_sel,
  input  logic [1:0] test_sel,
  input  logic       w1_lsb,
  input  logic       tick,
  input  logic       w2_lsb,
  output logic       gpo1,
  output logic       gpo2
);

  gsrc_e      src;
  logic [1:0] pin_val;

  always_comb begin
    if (tx_sel)       src = GSRC_TX;
    else if (cal_sel) src = GSRC_CAL;
    else              src = GSRC_NORM;

    case (src)
      GSRC_TX:  pin_val = tx_val;
      GSRC_CAL: pin_val = cal_val;
      default:  pin_val = norm_val;
    endcase

    gpo2 = pin_val[1];
    case (tsel_e'(test_sel))
      TSEL_W1LSB: gpo1 = w1_lsb;
      TSEL_TICK:  gpo1 = tick;
      TSEL_W2LSB: gpo1 = w2_lsb;
      default:    gpo1 = pin_val[0];
    endcase
  end

endmodule

// File: rtl/calwin_seq.sv
module calwin_seq
  import cws_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_LOG2    = 4,
  parameter int unsigned W1_BITS     = 8,
  parameter int unsigned W2_BITS     = 10
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               rx_en_pin,
  input  logic               tx_en_pin,
  input  logic               cal_arm,
  input  logic               start_cmd,
  input  logic               half_rate,
  input  logic [W1_BITS-1:0] win1_len,
  input  logic [W2_BITS-1:0] win2_len,
  input  logic               mute_en,
  input  logic               cal_ovr_en,
  input  logic [1:0]         cal_ovr_val,
  input  logic               tx_ovr_en,
  input  logic [1:0]         tx_ovr_val,
  input  logic [1:0]         gpo_norm,
  input  logic [1:0]         test_sel,
  output logic               cal_active,
  output logic               lna_mute,
  output logic               gpo1,
  output logic               gpo2,
  output logic               start_ack
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_i;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  // pin synchronizers
  logic rx_lvl, tx_lvl;

  cws_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
    .clk(clk_ref), .rst_n(rst_i), .d(rx_en_pin), .q(rx_lvl)
  );

  cws_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
    .clk(clk_ref), .rst_n(rst_i), .d(tx_en_pin), .q(tx_lvl)
  );

  // receive-enable edge detect
  logic rx_d_q;
  logic rx_rise;

  always_ff @(posedge clk_ref or negedge rst_i) begin
    if (!rst_i) rx_d_q <= 1'b0;
    else        rx_d_q <= rx_lvl;
  end
  assign rx_rise = rx_lvl & ~rx_d_q;

  // trigger and start command handshake
  logic cmd_take;
  logic trig;

  assign cmd_take  = start_cmd & rx_lvl;
  assign trig      = (cal_arm & rx_rise) | cmd_take;
  assign start_ack = cmd_take;

  // tick prescaler and the two windows
  logic w1_act, w2_act, w1_lsb, w2_lsb, tick;

  cws_tick #(.DIV_LOG2(DIV_LOG2)) u_tick (
    .clk(clk_ref), .rst_n(rst_i), .clr(trig), .run(w1_act | w2_act),
    .half_rate(half_rate), .tick(tick)
  );

  cws_window #(.W(W1_BITS)) u_win1 (
    .clk(clk_ref), .rst_n(rst_i), .trig(trig), .tick(tick),
    .len(win1_len), .active(w1_act), .cnt_lsb(w1_lsb)
  );

  cws_window #(.W(W2_BITS)) u_win2 (
    .clk(clk_ref), .rst_n(rst_i), .trig(trig), .tick(tick),
    .len(win2_len), .active(w2_act), .cnt_lsb(w2_lsb)
  );

  assign cal_active = w1_act;
  assign lna_mute   = mute_en & w2_act;

  cws_gpo_mux u_mux (
    .norm_val(gpo_norm), .cal_val(cal_ovr_val), .tx_val(tx_ovr_val),
    .cal_sel(cal_ovr_en & w2_act), .tx_sel(tx_ovr_en & tx_lvl),
    .test_sel(test_sel), .w1_lsb(w1_lsb), .tick(tick), .w2_lsb(w2_lsb),
    .gpo1(gpo1), .gpo2(gpo2)
  );

  AST_NO_SPONTANEOUS_RUN: assert property (@(posedge clk_ref) disable iff (!rst_i)
    (!trig && !cal_active) |=> !cal_active); // R2

  AST_ACK_STARTS_RUN: assert property (@(posedge clk_ref) disable iff (!rst_i)
    start_ack |=> (cal_active || $past(win1_len) == '0)); // R3

  AST_NO_ACK_WHEN_RX_LOW: assert property (@(posedge clk_ref) disable iff (!rst_i)
    !rx_lvl |-> !start_ack); // R3

  AST_TX_WINS: assert property (@(posedge clk_ref) disable iff (!rst_i)
    (tx_ovr_en && tx_lvl && test_sel == 2'b00) |-> ({gpo2, gpo1} == tx_ovr_val)); // R8

  AST_MUTE_ONLY_IN_RUN: assert property (@(posedge clk_ref) disable iff (!rst_i)
    (!trig && !lna_mute) |=> (!lna_mute || $past(w2_act))); // R6

endmodule

// File: tb/sim_calwin_seq.sv
module sim_calwin_seq;

  localparam int CLK_PERIOD  = 10;
  localparam int WDOG_CYCLES = 190000;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       rx_en_pin, tx_en_pin, cal_arm, start_cmd, half_rate;
  logic [7:0] win1_len;
  logic [9:0] win2_len;
  logic       mute_en, cal_ovr_en, tx_ovr_en;
  logic [1:0] cal_ovr_val, tx_ovr_val, gpo_norm, test_sel;
  logic       cal_active, lna_mute, gpo1, gpo2, start_ack;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  calwin_seq u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .rx_en_pin(rx_en_pin), .tx_en_pin(tx_en_pin),
    .cal_arm(cal_arm), .start_cmd(start_cmd), .half_rate(half_rate),
    .win1_len(win1_len), .win2_len(win2_len), .mute_en(mute_en),
    .cal_ovr_en(cal_ovr_en), .cal_ovr_val(cal_ovr_val), .tx_ovr_en(tx_ovr_en),
    .tx_ovr_val(tx_ovr_val), .gpo_norm(gpo_norm), .test_sel(test_sel),
    .cal_active(cal_active), .lna_mute(lna_mute), .gpo1(gpo1), .gpo2(gpo2),
    .start_ack(start_ack)
  );

  int n_chk = 0, n_fail = 0;
  int n_act, n_mute, n_ovr, n_tx, n_g1, n_g2, idx, first_act, first_g1;
  bit done = 1'b0;
  int l1s [5] = '{0, 1, 2, 3, 7};
  int l2s [4] = '{0, 1, 4, 5};

  task automatic check_eq(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic clr_counts();
    n_act = 0; n_mute = 0; n_ovr = 0; n_tx = 0; n_g1 = 0; n_g2 = 0;
    idx = 0; first_act = -1; first_g1 = -1;
  endtask

  // one clock, sampled 2 time units after the edge
  task automatic step();
    @(posedge clk_ref);
    #2;
    idx++;
    if (cal_active) n_act++;
    if (cal_active && first_act < 0) first_act = idx;
    if (lna_mute) n_mute++;
    if ({gpo2, gpo1} == cal_ovr_val) n_ovr++;
    if ({gpo2, gpo1} == tx_ovr_val) n_tx++;
    if (gpo1) n_g1++;
    if (gpo1 && first_g1 < 0) first_g1 = idx;
    if (gpo2) n_g2++;
  endtask

  task automatic settle();
    rx_en_pin = 1'b0;
    repeat (6) step();
  endtask

  task automatic rx_run(int n);
    clr_counts();
    rx_en_pin = 1'b1;
    repeat (n) step();
    rx_en_pin = 1'b0;
    repeat (4) step();
  endtask

  task automatic set_lens(int l1, int l2);
    win1_len = 8'(l1);
    win2_len = 10'(l2);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk_ref);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_en_pin = 1'b0; tx_en_pin = 1'b0; cal_arm = 1'b1;
    start_cmd = 1'b0; half_rate = 1'b0; set_lens(3, 5); mute_en = 1'b1;
    cal_ovr_en = 1'b1; cal_ovr_val = 2'b10; tx_ovr_en = 1'b0; tx_ovr_val = 2'b11;
    gpo_norm = 2'b01; test_sel = 2'b00;
    clr_counts();
    repeat (2) step();
    // R1 reset state
    check_eq("R1 reset cal_active", int'(cal_active), 0);
    check_eq("R1 reset lna_mute", int'(lna_mute), 0);
    check_eq("R1 reset start_ack", int'(start_ack), 0);
    check_eq("R1 reset pins", int'({gpo2, gpo1}), 1);
    rst_n = 1'b1;
    settle();
    check_eq("R1 idle pins", int'({gpo2, gpo1}), 1);
    check_eq("R1 idle cal_active", int'(cal_active), 0);

    // sweep: R5 R6 R7 R10 R4 across rates and lengths
    for (int h = 0; h < 2; h++) begin
      for (int a = 0; a < 5; a++) begin
        for (int b = 0; b < 4; b++) begin
          int u, l1, l2, mx;
          u = 16 << h; l1 = l1s[a]; l2 = l2s[b];
          mx = (l1 > l2) ? l1 : l2;
          half_rate = h[0];
          set_lens(l1, l2);
          rx_run(u * mx + 8);
          check_eq((l1 == 0) ? "R10 win1 zero" : "R5 win1 width", n_act, u * l1);
          check_eq((l2 == 0) ? "R10 mute zero" : "R6 mute width", n_mute, u * l2);
          check_eq((l2 == 0) ? "R10 ovr zero" : "R7 ovr width", n_ovr, u * l2);
          if (l1 > 0) check_eq("R5 start delay", first_act, 3);
          check_eq("R7 pins return", int'({gpo2, gpo1}), 1);
          settle();
        end
      end
    end
    half_rate = 1'b0;

    // long lengths
    set_lens(32, 292);
    rx_run(16 * 292 + 8);
    check_eq("R5 long win1", n_act, 512);
    check_eq("R6 long mute", n_mute, 4672);
    settle();

    // R11 test selector and R4 tick spacing
    for (int t = 1; t < 4; t++) begin
      for (int p = 0; p < 3; p++) begin
        int l1, l2, mx, expv;
        l1 = (p == 0) ? 3 : ((p == 1) ? 4 : 0);
        l2 = (p == 0) ? 5 : ((p == 1) ? 2 : 1);
        mx = (l1 > l2) ? l1 : l2;
        test_sel = 2'(t);
        set_lens(l1, l2);
        rx_run(16 * mx + 8);
        expv = (t == 1) ? 16 * (l1 / 2) : ((t == 2) ? mx : 16 * (l2 / 2));
        check_eq("R11 gpo1 test source", n_g1, expv);
        check_eq("R11 gpo2 unaffected", n_g2, 16 * l2);
        if (t == 2) check_eq("R4 first tick 26MHz", first_g1, 18);
        settle();
      end
    end
    test_sel = 2'b10; half_rate = 1'b1; set_lens(2, 3);
    rx_run(32 * 3 + 8);
    check_eq("R4 tick count 52MHz", n_g1, 3);
    check_eq("R4 first tick 52MHz", first_g1, 34);
    settle();
    test_sel = 2'b00; half_rate = 1'b0;

    // R2 arm clear
    cal_arm = 1'b0; set_lens(3, 5);
    rx_run(100);
    check_eq("R2 no run act", n_act, 0);
    check_eq("R2 no run mute", n_mute, 0);
    settle();

    // R3 start command with receive-enable high (arm still clear)
    rx_en_pin = 1'b1;
    repeat (6) step();
    set_lens(2, 3);
    clr_counts();
    start_cmd = 1'b1;
    #1;
    check_eq("R3 ack with rx high", int'(start_ack), 1);
    step();
    start_cmd = 1'b0;
    repeat (60) step();
    check_eq("R3 cmd win1", n_act, 32);
    check_eq("R3 cmd mute", n_mute, 48);
    check_eq("R3 cmd start", first_act, 1);
    settle();

    // R3 start command with receive-enable low
    clr_counts();
    start_cmd = 1'b1;
    #1;
    check_eq("R3 no ack rx low", int'(start_ack), 0);
    repeat (40) step();
    check_eq("R3 no run rx low", n_act, 0);
    start_cmd = 1'b0;
    settle();

    // R9 restart during a run
    cal_arm = 1'b1; set_lens(4, 5);
    clr_counts();
    rx_en_pin = 1'b1;
    repeat (30) step();
    start_cmd = 1'b1;
    #1;
    step();
    start_cmd = 1'b0;
    repeat (100) step();
    check_eq("R9 restart win1", n_act, 92);
    check_eq("R9 restart mute", n_mute, 108);
    settle();

    // R6 mute disabled, R7 override disabled
    mute_en = 1'b0; cal_ovr_en = 1'b0; set_lens(2, 3);
    rx_run(60);
    check_eq("R6 mute off", n_mute, 0);
    check_eq("R7 override off", n_ovr, 0);
    check_eq("R6 win1 still runs", n_act, 32);
    settle();
    mute_en = 1'b1; cal_ovr_en = 1'b1;

    // R8 transmit override timing
    tx_ovr_en = 1'b1;
    tx_en_pin = 1'b1;
    step();
    check_eq("R8 tx one edge", int'({gpo2, gpo1}), 1);
    step();
    check_eq("R8 tx two edges", int'({gpo2, gpo1}), 3);
    tx_en_pin = 1'b0;
    step();
    check_eq("R8 tx fall one edge", int'({gpo2, gpo1}), 3);
    step();
    check_eq("R8 tx fall two edges", int'({gpo2, gpo1}), 1);

    // R8 priority over calibration override
    tx_en_pin = 1'b1;
    repeat (3) step();
    rx_run(16 * 3 + 8);
    check_eq("R8 tx wins cal", n_ovr, 0);
    check_eq("R8 tx held", n_tx, 16 * 3 + 12);
    tx_ovr_en = 1'b0;
    step();
    check_eq("R8 tx override off", int'({gpo2, gpo1}), 1);
    tx_en_pin = 1'b0;
    settle();

    done = 1'b1;
    report();
    $finish;
  end

endmodule